// File: doc/BRIEF.md
# Handshake Line Control Register

This block is the control side of one half of a classic parallel peripheral adapter. It holds a six-bit control word that the CPU writes over a small register bus. It watches two handshake pins, and it reports two latched event flags together with an active-low interrupt request. The first handshake pin is an event input only. The second pin is an event input too, unless the control word turns it into an output whose level software sets directly. One control bit is passed through to the neighbouring data-port logic, which uses it to choose between the direction register and the data register.

Each input pin passes through a two-flop synchronizer before edge detection. A flag is set only by a transition of the selected polarity, never by a level. A flag whose enable bit is set pulls the interrupt line low. The flags are status only: a CPU read of the data-port location clears them. Reading the control location shows them without clearing them, so an interrupt service routine can see which pin fired before it acknowledges.

Top module: `hsl_ctrl`

## Requirements
- R1: After synchronous reset, the control read value is 0x00, irq_n is 1, line2_oe is 0, line2_out is 1 and ddr_sel is 0.
- R2: A write with bus_addr=1 stores bus_wdata[5:0] as the control bits. bus_rdata returns {flag1, flag2, control[5:0]}, so written bits 7 and 6 are ignored.
- R3: Line 1 sets flag1 (read bit 7) on a falling transition when control bit 1 is 0 and on a rising transition when it is 1. The opposite transition has no effect. The flag is visible after the third rising clock edge that follows the pin change.
- R4: With control bit 5 at 0, line 2 sets flag2 (read bit 6) on a falling transition when control bit 4 is 0 and on a rising transition when it is 1. The same three-edge latency applies.
- R5: A pin held at a steady level never sets a flag, however long it is held.
- R6: irq_n is 0 exactly when (flag1 and control bit 0) or (flag2 and control bit 3 and control bit 5 at 0). A flag with its enable at 0 is still readable but leaves irq_n at 1.
- R7: A read with bus_addr=0 clears both flags at the next clock edge. A read with bus_addr=1 does not clear them. An edge that would set a flag on the same edge as the clear leaves that flag set.
- R8: With control bit 5 at 1, line2_oe is 1. If bit 4 is 1, line2_out equals bit 3. If bit 4 is 0, line2_out stays 1. With bit 5 at 0, line2_oe is 0 and line2_out is 1. Writing 0x3C drives line 2 high.
- R9: With control bit 5 at 1, transitions on line2_in never set flag2 and never affect irq_n.
- R10: ddr_sel always equals control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data-port location, 1 = control location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Control read view {flag1, flag2, control[5:0]} |
| line1_in | input | 1 | Handshake pin 1 (event input) |
| line2_in | input | 1 | Handshake pin 2 when used as an input |
| line2_out | output | 1 | Handshake pin 2 drive level |
| line2_oe | output | 1 | Handshake pin 2 output enable |
| ddr_sel | output | 1 | Direction/data register select for the port logic |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong polarity select or a broken synchronizer stage shows at bus_rdata bit 7 or 6 on the third clock edge after a pin change. A flag that sets one edge early or late is caught by sampling exactly at that edge. A clear that is lost, or a clear that wins against a coincident edge, shows in the next read view and at irq_n one cycle after the port read. Wrong gating of the line 2 mode shows as a spurious flag or an interrupt while the pin is an output, or as a wrong drive level right after the control write.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    localparam int DATA_W = 8;
    localparam int CTL_W  = 6;
    localparam int NLINES = 2;

    localparam logic ADDR_PORT = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    // Control bits, MSB first: bit 5 down to bit 0
    typedef struct packed {
        logic l2_out;   // 5: line 2 is an output
        logic l2_sel;   // 4: line 2 edge polarity / direct-drive select
        logic l2_aux;   // 3: line 2 interrupt enable / drive level
        logic ddr;      // 2: direction register access select
        logic l1_rise;  // 1: line 1 rising edge select
        logic l1_en;    // 0: line 1 interrupt enable
    } ctl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic ctl_t ctl_from_bus(input logic [DATA_W-1:0] d);
        return ctl_t'(d[CTL_W-1:0]);
    endfunction

    function automatic logic edge_hit(input logic rise_sel, input edge_t e);
        return rise_sel ? e.rise : e.fall;
    endfunction

    function automatic logic l2_level(input ctl_t c);
        return (c.l2_out && c.l2_sel) ? c.l2_aux : 1'b1;
    endfunction

endpackage

// File: rtl/hsl_edge.sv
module hsl_edge
    import hsl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ev
);

    localparam int CHAIN_W = STAGES + 1;

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], din};
        end
    end

    always_comb begin
        ev.rise = chain[STAGES-1] & ~chain[STAGES];
        ev.fall = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/hsl_flags.sv
module hsl_flags
    import hsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_t       ctl,
    input  edge_t      ev1,
    input  edge_t      ev2,
    input  logic       clr,
    output logic [1:0] flag,   // [1] = line 1, [0] = line 2
    output logic       irq_n
);

    logic set1, set2;

    always_comb begin
        set1 = edge_hit(ctl.l1_rise, ev1);
        set2 = ~ctl.l2_out & edge_hit(ctl.l2_sel, ev2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 2'b00;
        end else begin
            flag[1] <= set1 | (flag[1] & ~clr);
            flag[0] <= set2 | (flag[0] & ~clr);
        end
    end

    always_comb begin
        irq_n = ~((flag[1] & ctl.l1_en) | (flag[0] & ctl.l2_aux & ~ctl.l2_out));
    end

    // R3, R5: flag 1 only rises after the edge detector reported a transition
    p_flag1_from_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[1]) |-> $past(ev1.rise | ev1.fall));

    // R7: a clear with no coincident event empties flag 1
    p_clear_flag1_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !set1) |=> !flag[1]);

    // R9: line 2 in output mode never raises its flag
    p_out_no_flag_r9: assert property (@(posedge clk) disable iff (rst)
        ctl.l2_out |=> !$rose(flag[0]));

endmodule

// File: rtl/hsl_ctrl.sv
module hsl_ctrl
    import hsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              line1_in,
    input  logic              line2_in,
    output logic              line2_out,
    output logic              line2_oe,
    output logic              ddr_sel,
    output logic              irq_n
);

    ctl_t        ctl;
    logic        ctl_wr, port_rd;
    logic [1:0]  flag;
    logic [NLINES-1:0] pins;
    edge_t       ev [NLINES];

    assign ctl_wr  = bus_sel &  bus_wr & (bus_addr == ADDR_CTRL);
    assign port_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_PORT);
    assign pins    = {line2_in, line1_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl_wr) begin
            ctl <= ctl_from_bus(bus_wdata);
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        hsl_edge #(.STAGES(SYNC_STAGES)) edge_i (
            .clk (clk),
            .rst (rst),
            .din (pins[g]),
            .ev  (ev[g])
        );
    end

    hsl_flags flags_i (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .ev1   (ev[0]),
        .ev2   (ev[1]),
        .clr   (port_rd),
        .flag  (flag),
        .irq_n (irq_n)
    );

    assign bus_rdata = {flag, ctl};
    assign line2_oe  = ctl.l2_out;
    assign line2_out = l2_level(ctl);
    assign ddr_sel   = ctl.ddr;

    // R8: the output enable follows bit 5 of the last control write
    p_oe_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (line2_oe == $past(bus_wdata[5])));

    // R6: the request only releases after an acknowledge or a control change
    p_irq_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n) |-> $past(port_rd || ctl_wr));

endmodule

// File: tb/hsl_ctrl_tb_top.sv
module hsl_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_wr, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       line1_in, line2_in;
    logic       line2_out, line2_oe, ddr_sel, irq_n;

    int errors = 0;
    int checks = 0;

    logic [5:0] m_ctl;
    logic       m_f1, m_f2;

    always #5 clk = ~clk;

    hsl_ctrl dut_i (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line1_in(line1_in), .line2_in(line2_in),
        .line2_out(line2_out), .line2_oe(line2_oe),
        .ddr_sel(ddr_sel), .irq_n(irq_n)
    );

    function automatic logic exp_irq_n();
        return !((m_f1 && m_ctl[0]) || (m_f2 && m_ctl[3] && !m_ctl[5]));
    endfunction

    function automatic logic exp_l2out();
        return (m_ctl[5] && m_ctl[4]) ? m_ctl[3] : 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 rdata"}, bus_rdata, {m_f1, m_f2, m_ctl});
        chk({tag, " R6 irq_n"}, {7'd0, irq_n}, {7'd0, exp_irq_n()});
        chk({tag, " R8 line2_out"}, {7'd0, line2_out}, {7'd0, exp_l2out()});
        chk({tag, " R8 line2_oe"}, {7'd0, line2_oe}, {7'd0, m_ctl[5]});
        chk({tag, " R10 ddr_sel"}, {7'd0, ddr_sel}, {7'd0, m_ctl[2]});
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = v;
        tick(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
        m_ctl = v[5:0];
    endtask

    task automatic rd(input logic a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        tick(1);
        bus_sel = 1'b0;
        if (a == 1'b0) begin
            m_f1 = 1'b0; m_f2 = 1'b0;
        end
    endtask

    // Toggle a pin and update the model; caller waits for the flag latency
    task automatic toggle(input int which);
        logic nv;
        if (which == 1) begin
            nv = ~line1_in;
            line1_in = nv;
            if (nv == m_ctl[1]) m_f1 = 1'b1;
        end else begin
            nv = ~line2_in;
            line2_in = nv;
            if (!m_ctl[5] && nv == m_ctl[4]) m_f2 = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
        line1_in = 1'b0; line2_in = 1'b0;
        m_ctl = 6'h00; m_f1 = 1'b0; m_f2 = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        check_all("R1 reset");

        // R2: bits 7:6 of the write are ignored
        wr_ctrl(8'hFF);
        chk("R2 readback of FF", bus_rdata, 8'h3F);
        check_all("R2");

        // R8: direct drive levels
        wr_ctrl(8'h3C);
        chk("R8 0x3C drives high", {6'd0, line2_oe, line2_out}, 8'h03);
        wr_ctrl(8'h34);
        chk("R8 bit3=0 drives low", {6'd0, line2_oe, line2_out}, 8'h02);
        chk("R10 ddr_sel set", {7'd0, ddr_sel}, 8'h01);
        wr_ctrl(8'h24);
        chk("R8 bit4=0 stays high", {6'd0, line2_oe, line2_out}, 8'h03);

        // R3: rising edge on line 1, exact latency
        wr_ctrl(8'h03);
        toggle(1);
        tick(2);
        chk("R3 flag not yet after two edges", bus_rdata, 8'h03);
        tick(1);
        chk("R3 flag after third edge", bus_rdata, 8'h83);
        chk("R6 irq asserted", {7'd0, irq_n}, 8'h00);
        // R7: reading control does not clear, port read does
        rd(1'b1);
        chk("R7 ctrl read keeps flag", bus_rdata, 8'h83);
        rd(1'b0);
        chk("R7 port read clears", bus_rdata, 8'h03);
        chk("R6 irq released", {7'd0, irq_n}, 8'h01);

        // R3: falling polarity, opposite edge ignored
        wr_ctrl(8'h01);
        toggle(1); tick(4);          // 1 -> 0, falling: sets
        check_all("R3 falling");
        rd(1'b0);
        toggle(1); tick(4);          // 0 -> 1, rising: ignored
        chk("R3 rising ignored when falling selected", bus_rdata, 8'h01);

        // R5: steady high level for a long time
        tick(20);
        chk("R5 steady level no flag", bus_rdata, 8'h01);

        // R6: flag without enable, then enable it
        wr_ctrl(8'h00);
        toggle(1); tick(4);          // falling, sets, not enabled
        chk("R6 flag visible without enable", bus_rdata, 8'h80);
        chk("R6 irq stays high when disabled", {7'd0, irq_n}, 8'h01);
        wr_ctrl(8'h01);
        chk("R6 irq on enabling", {7'd0, irq_n}, 8'h00);
        rd(1'b0);

        // R4: line 2 rising then falling polarity
        wr_ctrl(8'h18);
        toggle(2); tick(4);
        check_all("R4 rising");
        rd(1'b0);
        wr_ctrl(8'h08);
        toggle(2); tick(4);
        check_all("R4 falling");
        rd(1'b0);

        // R7: edge coincides with the clearing read
        wr_ctrl(8'h03);
        line1_in = 1'b0; tick(4);    // line 1 was low already: no event
        line1_in = 1'b1; m_f1 = 1'b1;
        tick(2);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
        tick(1);
        bus_sel = 1'b0;
        chk("R7 coincident edge keeps flag", bus_rdata, 8'h83);
        rd(1'b0);

        // R9: output mode ignores line 2
        wr_ctrl(8'h38);
        toggle(2); tick(4);
        toggle(2); tick(4);
        chk("R9 no flag in output mode", bus_rdata, 8'h38);
        chk("R9 no irq in output mode", {7'd0, irq_n}, 8'h01);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: wr_ctrl(8'($urandom()));
                1: rd(1'($urandom()));
                2: begin toggle(1); tick(4); end
                3: begin toggle(2); tick(4); end
                default: tick(int'($urandom_range(1, 6)));
            endcase
            check_all("rand R3 R4 R6 R7 R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule